// File: doc/BRIEF.md
# Multiplexed Parallel Memory Read Sequencer

This block runs read cycles on an external 16-bit memory whose address and data travel on one set of shared pins. Each address phase raises an address-latch strobe for two clocks while the block drives the address. The block keeps the address on the pins for one more clock, then releases them. One or more read strobes follow, and the memory drives data onto the released pins. Every interval is a whole number of peripheral clock cycles. A set of static configuration inputs selects the strobe width, an optional hold cycle, a flash recovery gap, the latch-strobe polarity and the addressing mode.

A client raises a one-cycle request that carries a start halfword address and a word count. The block answers with a one-cycle acknowledge. It returns each fetched halfword with a one-cycle valid pulse. After the last word it pulses done and goes back to idle. In single mode every word gets its own address phase, and the address steps by one each time. In burst mode one address phase is followed by all the read pulses, and the memory steps its own address.

Top module: `mpx_rd_seq`

## Requirements
- R1: While reset is held and while idle, `rd_n` is 1, `ad_oe` is 0, `done`, `rvalid` and `ack` are 0, and `ale` sits at its inactive level. The inactive level is 0 when `cfg_ale_low`=0.
- R2: In each address phase the latch strobe is active for exactly two consecutive cycles. During both cycles `ad_oe` is 1 and `ad_out` carries the phase's address: `start_addr` plus the word index in single mode, and `start_addr` in burst mode.
- R3: In the first cycle after the latch strobe goes inactive, `ad_oe` stays 1. In the second cycle it is 0, and it remains 0 whenever `rd_n` is 0.
- R4: After an address phase, `rd_n` first goes low two cycles after the first inactive latch-strobe cycle.
- R5: Each read pulse keeps `rd_n` low for `cfg_dur` cycles (5-bit field). A value of 0 gives one cycle.
- R6: In burst mode, `rd_n` stays high for `cfg_hold`+1 cycles between consecutive read pulses.
- R7: In single mode, between a read pulse and the next address phase, `rd_n` is high and the latch strobe inactive for `cfg_hold` + 7·`cfg_flash` cycles.
- R8: With `cfg_burst`=0 a transfer of N words has N address phases. With `cfg_burst`=1 it has exactly one address phase and N read pulses.
- R9: `rdata` takes the value `ad_in` had in the last low cycle of each read pulse. `rvalid` is high for one cycle, the first cycle with `rd_n` high again. A transfer gives exactly N such pulses, in address order.
- R10: With `cfg_ale_low`=1 the latch strobe is inverted: idle level 1, active level 0.
- R11: A request in idle with nonzero `xfer_len` produces a one-cycle `ack` in the next cycle. A request with `xfer_len`=0, or a request made while busy, is ignored. `done` pulses once, `cfg_hold` cycles after the final `rd_n` rise, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transfer request pulse |
| xfer_len | input | 8 | Number of halfwords to read |
| start_addr | input | 16 | First halfword address |
| cfg_dur | input | 5 | Read strobe width in cycles (0 means 1) |
| cfg_hold | input | 1 | Add a hold cycle after each read strobe |
| cfg_flash | input | 1 | Add a 7-cycle recovery before each new address phase |
| cfg_ale_low | input | 1 | Latch strobe is active low |
| cfg_burst | input | 1 | Issue all read pulses under one address phase |
| ack | output | 1 | Request accepted |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| ad_out | output | 16 | Address driven onto the shared pins |
| ad_oe | output | 1 | Output enable of the shared pins |
| ad_in | input | 16 | Data read from the shared pins |
| rdata | output | 16 | Captured halfword |
| rvalid | output | 1 | `rdata` is valid this cycle |
| done | output | 1 | Transfer finished |

## Verification
The valid pulse for the last word and the done pulse coincide in the first cycle after the final read strobe rises whenever the hold cycle is off. With the hold cycle on, done comes one cycle later. The bench runs transfers with and without the hold cycle. It timestamps both pulses against the observed `rd_n` rising edge, and requires done to carry the same cycle number as the final valid pulse, plus the hold term. It also checks that the data on the last pulse is still the final halfword.

// File: rtl/mpx_rd_pkg.sv
// Package: shared state encoding and sizes for the multiplexed read sequencer.
// Assumes nothing; imported by all sequencer modules.
package mpx_rd_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_ALE1, S_ALE2, S_AHLD, S_TURN,
        S_RD, S_HOLD, S_GAP, S_RECOV, S_DONE
    } seq_state_t;
    localparam int FLASH_GAP = 7;
endpackage

// File: rtl/mpx_rd_fsm.sv
// Sequencing core: accepts a request, steps through address phase, turnaround,
// read pulses, hold, burst gap and flash recovery, and counts words.
// Assumes configuration is latched at acceptance and held for the transfer.
module mpx_rd_fsm
    import mpx_rd_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int LEN_W = 8,
    parameter int DUR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [BUS_W-1:0] start_addr,
    input  logic [DUR_W-1:0] cfg_dur,
    input  logic             cfg_hold,
    input  logic             cfg_flash,
    input  logic             cfg_burst,
    output logic             ack,
    output seq_state_t       state,
    output logic [BUS_W-1:0] cur_addr,
    output logic             strobe_end
);
    localparam int CNT_W = (DUR_W > 3) ? DUR_W : 3;

    logic [LEN_W-1:0] left;
    logic [DUR_W-1:0] dur_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dur_eff;
    logic             hold_q, flash_q, burst_q;

    // Effective strobe width: a zero field still gives one cycle.
    always_comb dur_eff = (dur_q == '0) ? CNT_W'(1) : CNT_W'(dur_q);

    // Last cycle of the current read pulse.
    always_comb strobe_end = (state == S_RD) && (cnt == dur_eff - CNT_W'(1));

    // Choose where to go once a word's read (and hold) is complete.
    function automatic seq_state_t after_word(input logic last, input logic burst,
                                              input logic flash);
        if (last)       return S_DONE;
        else if (burst) return S_GAP;
        else if (flash) return S_RECOV;
        else            return S_ALE1;
    endfunction

    // Main state register, word counter, address and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ack      <= 1'b0;
            left     <= '0;
            cur_addr <= '0;
            dur_q    <= '0;
            cnt      <= '0;
            hold_q   <= 1'b0;
            flash_q  <= 1'b0;
            burst_q  <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (state)
                S_IDLE: if (req && (xfer_len != '0)) begin
                    state    <= S_ALE1;
                    ack      <= 1'b1;
                    left     <= xfer_len;
                    cur_addr <= start_addr;
                    dur_q    <= cfg_dur;
                    hold_q   <= cfg_hold;
                    flash_q  <= cfg_flash;
                    burst_q  <= cfg_burst;
                end
                S_ALE1: state <= S_ALE2;
                S_ALE2: state <= S_AHLD;
                S_AHLD: state <= S_TURN;
                S_TURN: begin
                    state <= S_RD;
                    cnt   <= '0;
                end
                S_RD: if (strobe_end) begin
                    left     <= left - LEN_W'(1);
                    cur_addr <= cur_addr + BUS_W'(1);
                    cnt      <= '0;
                    state    <= hold_q ? S_HOLD
                                       : after_word(left == LEN_W'(1), burst_q, flash_q);
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                S_HOLD: begin
                    cnt   <= '0;
                    state <= after_word(left == '0, burst_q, flash_q);
                end
                S_GAP: state <= S_RD;
                S_RECOV: if (cnt == CNT_W'(FLASH_GAP - 1)) begin
                    cnt   <= '0;
                    state <= S_ALE1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mpx_rd_capture.sv
// Data capture: registers the shared-bus data on the last low cycle of each
// read pulse and presents it with a one-cycle valid.
// Assumes strobe_end is high for exactly one cycle per read pulse.
module mpx_rd_capture #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_end,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] rdata,
    output logic             rvalid
);
    // Capture register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= strobe_end;
            if (strobe_end) rdata <= ad_in;
        end
    end
endmodule

// File: rtl/mpx_rd_pins.sv
// Pin decode: derives strobe levels and bus drive from the sequencer state.
// Assumes the polarity input is static while a transfer runs.
module mpx_rd_pins
    import mpx_rd_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  seq_state_t       state,
    input  logic [BUS_W-1:0] cur_addr,
    input  logic             cfg_ale_low,
    output logic             ale,
    output logic             rd_n,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe
);
    logic ale_act;

    // Strobe and drive decode.
    always_comb begin
        ale_act = (state == S_ALE1) || (state == S_ALE2);
        ale     = ale_act ^ cfg_ale_low;
        rd_n    = (state != S_RD);
        ad_oe   = ale_act || (state == S_AHLD);
        ad_out  = ad_oe ? cur_addr : '0;
    end
endmodule

// File: rtl/mpx_rd_seq.sv
// Top: multiplexed address/data read sequencer for 16-bit external memory.
// Assumes configuration inputs are stable from request until done.
module mpx_rd_seq
    import mpx_rd_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int LEN_W = 8,
    parameter int DUR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [BUS_W-1:0] start_addr,
    input  logic [DUR_W-1:0] cfg_dur,
    input  logic             cfg_hold,
    input  logic             cfg_flash,
    input  logic             cfg_ale_low,
    input  logic             cfg_burst,
    output logic             ack,
    output logic             ale,
    output logic             rd_n,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] rdata,
    output logic             rvalid,
    output logic             done
);
    seq_state_t       state;
    logic [BUS_W-1:0] cur_addr;
    logic             strobe_end;

    mpx_rd_fsm #(.BUS_W(BUS_W), .LEN_W(LEN_W), .DUR_W(DUR_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_len(xfer_len),
        .start_addr(start_addr), .cfg_dur(cfg_dur), .cfg_hold(cfg_hold),
        .cfg_flash(cfg_flash), .cfg_burst(cfg_burst), .ack(ack),
        .state(state), .cur_addr(cur_addr), .strobe_end(strobe_end)
    );

    mpx_rd_capture #(.BUS_W(BUS_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .strobe_end(strobe_end), .ad_in(ad_in),
        .rdata(rdata), .rvalid(rvalid)
    );

    mpx_rd_pins #(.BUS_W(BUS_W)) pins_i (
        .state(state), .cur_addr(cur_addr), .cfg_ale_low(cfg_ale_low),
        .ale(ale), .rd_n(rd_n), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    // Completion flag: high for the single cycle spent in the done state.
    always_comb done = (state == S_DONE);
endmodule

// File: rtl/mpx_rd_seq_chk.sv
// Checker: port-level timing properties of the read sequencer, bound to the top.
// Assumes the polarity input is static while a transfer runs.
module mpx_rd_seq_chk #(
    parameter int BUS_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic cfg_ale_low,
    input logic ack,
    input logic ale,
    input logic rd_n,
    input logic ad_oe,
    input logic rvalid,
    input logic done
);
    logic ale_act;
    always_comb ale_act = ale ^ cfg_ale_low;

    // R2: a newly active latch strobe stays active for a second cycle.
    p_ale_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_act && !$past(ale_act)) |=> ale_act);
    // R2: the latch strobe never stays active for a third cycle.
    p_ale_max_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_act && $past(ale_act)) |=> !ale_act);
    // R2: the address is driven while the latch strobe is active.
    p_addr_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_act |-> ad_oe);
    // R3: the bus is released while the read strobe is low.
    p_bus_free_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R4: the read strobe never overlaps the latch strobe.
    p_rd_no_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ale_act);
    // R9: valid appears only in the first cycle after a read strobe rise.
    p_valid_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (rd_n && !$past(rd_n)));
    // R11: an acknowledge is always preceded by a request.
    p_ack_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req));
    // R11: after done the block sits idle.
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rd_n && !ad_oe && !rvalid && !done));
endmodule

bind mpx_rd_seq mpx_rd_seq_chk #(.BUS_W(BUS_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_ale_low(cfg_ale_low), .ack(ack),
    .ale(ale), .rd_n(rd_n), .ad_oe(ad_oe), .rvalid(rvalid), .done(done)
);

// File: tb/mpx_rd_seq_tb_top.sv
// Directed bench for the multiplexed read sequencer with a behavioural memory.
module mpx_rd_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  xfer_len = '0;
    logic [15:0] start_addr = '0;
    logic [4:0]  cfg_dur = '0;
    logic        cfg_hold = 1'b0, cfg_flash = 1'b0, cfg_ale_low = 1'b0, cfg_burst = 1'b0;
    logic        ack, ale, rd_n, ad_oe, rvalid, done;
    logic [15:0] ad_out, ad_in, rdata;

    int n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    mpx_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_len(xfer_len),
        .start_addr(start_addr), .cfg_dur(cfg_dur), .cfg_hold(cfg_hold),
        .cfg_flash(cfg_flash), .cfg_ale_low(cfg_ale_low), .cfg_burst(cfg_burst),
        .ack(ack), .ale(ale), .rd_n(rd_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .rdata(rdata), .rvalid(rvalid), .done(done)
    );

    function automatic logic [15:0] mem_f(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    // Behavioural memory state and monitor bookkeeping.
    logic [15:0] lat_addr = '0, base_b = '0;
    int rd_idx = 0, cyc = 0;
    int ale_run = 0, rd_run = 0, hi_run = 0, since_fall = 0;
    int fall_cyc = 0, rise_cyc = 0, done_cyc = 0, last_val_cyc = 0;
    int n_ale = 0, n_rd = 0, n_val = 0, n_ack = 0, n_done = 0;
    int e_ale = 0, e_addr = 0, e_hold = 0, e_delay = 0, e_width = 0;
    int e_gap = 0, e_rec = 0, e_data = 0, e_vt = 0, e_done = 0;
    bit prev_a = 0, prev_rd = 1, after_ale = 0, rise_seen = 0;
    int exp_w = 1, exp_h = 0, exp_f = 0;

    assign ad_in = ad_oe ? 16'h0000 : mem_f(lat_addr + 16'(rd_idx));

    // Negative-edge monitor: measures every interval at the pins.
    always @(negedge clk) begin
        bit a;
        cyc++;
        a = ale ^ cfg_ale_low;
        if (rst_n) begin
            if (a) begin
                if (!prev_a && rise_seen && hi_run != exp_h + 7 * exp_f) e_rec++;
                ale_run++;
                if (!(ad_oe && ad_out == base_b + 16'(cfg_burst ? 0 : n_ale))) e_addr++;
                lat_addr = ad_out;
                rd_idx = 0;
            end else if (prev_a) begin
                if (ale_run != 2) e_ale++;
                ale_run = 0; n_ale++; fall_cyc = cyc; since_fall = 1; after_ale = 1;
            end else if (since_fall != 0) begin
                since_fall++;
            end
            if (since_fall == 1 && !ad_oe) e_hold++;
            if (since_fall == 2) begin
                if (ad_oe) e_hold++;
                since_fall = 0;
            end
            if (!rd_n) begin
                if (prev_rd) begin
                    n_rd++;
                    if (after_ale) begin
                        if (cyc - fall_cyc != 2) e_delay++;
                    end else if (hi_run != exp_h + 1) e_gap++;
                    after_ale = 0; hi_run = 0;
                end
                rd_run++;
            end else begin
                if (!prev_rd) begin
                    if (rd_run != exp_w) e_width++;
                    rd_run = 0; rd_idx++; rise_cyc = cyc; rise_seen = 1;
                end
                if (!a) hi_run++;
            end
            if (rvalid) begin
                if (cyc != rise_cyc) e_vt++;
                if (rdata != mem_f(base_b + 16'(n_val))) e_data++;
                n_val++; last_val_cyc = cyc;
            end
            if (ack) n_ack++;
            if (done) begin
                n_done++; done_cyc = cyc;
                if (cyc != rise_cyc + exp_h) e_done++;
            end
        end
        prev_a = a; prev_rd = rd_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #1;
        n_ale = 0; n_rd = 0; n_val = 0; n_ack = 0; n_done = 0;
        e_ale = 0; e_addr = 0; e_hold = 0; e_delay = 0; e_width = 0;
        e_gap = 0; e_rec = 0; e_data = 0; e_vt = 0; e_done = 0;
        rise_seen = 0; after_ale = 0; since_fall = 0;
    endtask

    task automatic idle_check(input string tag);
        chk(rd_n === 1'b1 && ad_oe === 1'b0 && done === 1'b0 && rvalid === 1'b0
            && ack === 1'b0 && ale === cfg_ale_low, tag,
            {rd_n, ad_oe, done, rvalid, ack, ale}, {5'b10000, cfg_ale_low});
    endtask

    // One transfer with full interval checking; optionally re-requests while busy.
    task automatic run_xfer(input int len, input logic [15:0] addr, input int dur,
                            input bit h, input bit f, input bit burst, input bit pol,
                            input bit poke_busy);
        int wait_c;
        cfg_dur = 5'(dur); cfg_hold = h; cfg_flash = f; cfg_burst = burst;
        cfg_ale_low = pol; xfer_len = 8'(len); start_addr = addr;
        exp_w = (dur == 0) ? 1 : dur; exp_h = h; exp_f = f; base_b = addr;
        clear_mon();
        @(negedge clk); idle_check("R10 idle level before start");
        req = 1'b1;
        @(negedge clk); req = 1'b0;
        chk(ack === 1'b1, "R11 ack next cycle", ack, 1);
        if (poke_busy) begin
            repeat (4) @(negedge clk);
            req = 1'b1; @(negedge clk); req = 1'b0;
        end
        wait_c = 0;
        while (n_done == 0 && wait_c < 5000) begin @(negedge clk); wait_c++; end
        repeat (3) @(negedge clk);
        chk(e_ale == 0, "R2 strobe width two", e_ale, 0);
        chk(e_addr == 0, "R2 address during strobe", e_addr, 0);
        chk(e_hold == 0, "R3 address hold then release", e_hold, 0);
        chk(e_delay == 0, "R4 read two cycles after strobe", e_delay, 0);
        chk(e_width == 0, "R5 read pulse width", e_width, 0);
        chk(e_gap == 0, "R6 burst gap", e_gap, 0);
        chk(e_rec == 0, "R7 recovery before next address", e_rec, 0);
        chk(n_ale == (burst ? 1 : len), "R8 address phase count", n_ale, burst ? 1 : len);
        chk(n_rd == len, "R8 read pulse count", n_rd, len);
        chk(e_data == 0, "R9 data value", e_data, 0);
        chk(e_vt == 0, "R9 valid timing", e_vt, 0);
        chk(n_val == len, "R9 valid count", n_val, len);
        chk(n_ack == 1, "R11 single ack", n_ack, 1);
        chk(n_done == 1, "R11 single done", n_done, 1);
        chk(e_done == 0, "R11 done timing", e_done, 0);
        chk(done_cyc == last_val_cyc + exp_h, "R11 done versus last valid",
            done_cyc - last_val_cyc, exp_h);
        idle_check(pol ? "R10 inverted idle after done" : "R1 idle after done");
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        idle_check("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 after reset");
    endtask

    task automatic test_zero_len();
        clear_mon();
        xfer_len = 8'd0; cfg_ale_low = 1'b0;
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        repeat (6) @(negedge clk);
        chk(n_ack == 0 && n_ale == 0, "R11 zero length ignored", n_ack + n_ale, 0);
        idle_check("R11 idle after zero length");
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        test_reset();
        run_xfer(1, 16'h1234, 3, 0, 0, 0, 0, 0);   // R9 basic single word
        run_xfer(3, 16'h00FE, 5, 1, 1, 0, 0, 1);   // R7 hold and flash, busy poke R11
        run_xfer(3, 16'h4000, 2, 0, 1, 0, 0, 0);   // R7 flash only
        run_xfer(4, 16'hA0F0, 2, 1, 0, 1, 0, 0);   // R6 burst with hold
        run_xfer(3, 16'h7FFF, 1, 0, 0, 1, 0, 0);   // R6 burst no hold
        run_xfer(2, 16'h0010, 0, 0, 0, 0, 0, 0);   // R5 zero width field
        run_xfer(1, 16'hFFFF, 31, 1, 0, 0, 0, 0);  // R5 widest pulse
        run_xfer(2, 16'h5555, 4, 0, 0, 0, 1, 0);   // R10 inverted strobe
        run_xfer(2, 16'h2222, 3, 1, 1, 1, 1, 0);   // R10 inverted burst
        test_zero_len();
        finish_run();
    end
endmodule